// File: doc/BRIEF.md
# Dual-Source Change-of-Flow Trace Buffer

This block captures program flow from two independent instruction streams: a main CPU with 24-bit program counters and a coprocessor with 16-bit program counters. It can also capture data accesses in a detail mode. Each captured record is packed into a 64-bit line of a 64-line on-chip array. A two-bit mode input selects what is captured. The choices are flow from both sources, flow from the CPU alone, flow from the coprocessor alone, or data-access detail.

Records are accepted only while `trace_en` is high. An entry counter reports progress. Its upper bits give the line index and bit 0 shows that a line is half filled in the single-source flow modes. When the last line has been written, the buffer either stops or wraps back to line 0. A registered read port returns any line one cycle after it is requested.

Top module: `cof_trace_buf`

## Requirements
- R1: In mode 0 (both sources), a change-of-flow strobe from either source writes one line. Byte 7 holds the coprocessor info byte, byte 6 is zero, bytes 5..4 hold the coprocessor PC, byte 3 holds the CPU info byte and bytes 2..0 hold the CPU PC. An info byte is {valid, attr[6:0]}. The valid bit is set only for the source that strobed; the other source's PC is stored as a snapshot with valid clear.
- R2: In mode 0, strobes from both sources in the same cycle write a single line with both valid bits set.
- R3: In mode 1 (CPU only), each line holds two entries of the form {1'b1, cpu_attr, cpu_pc}. The older entry sits in bytes 3..0 and the newer one in bytes 7..4.
- R4: In mode 2 (coprocessor only), each entry is {1'b1, cop_attr, cop_pc}. The older entry sits in bytes 2..0 and the newer one in bytes 6..4; bytes 7 and 3 are zero.
- R5: `cnt_o` is {line index, half bit}. In modes 1 and 2 the half bit toggles on every entry and the line index advances when a line completes. In modes 0 and 3 the half bit stays 0 and the line index advances on every line written.
- R6: In mode 3 (detail), an access strobe writes one line. Byte 7 is {rd, word, det_src, 5'b0}, bytes 6..4 hold the CPU address, bytes 3..2 hold the data and bytes 1..0 hold the coprocessor address.
- R7: A byte access stores `acc_data[7:0]` in byte 2 and clears byte 3. A word access stores the byte at the lower address (`acc_data[15:8]`) in byte 3 and the byte at the higher address (`acc_data[7:0]`) in byte 2.
- R8: Strobes are ignored, leaving the counter and the array unchanged, in these cases: while `trace_en` is low; the untraced source's strobe in modes 1 and 2; access strobes in the flow modes; change-of-flow strobes in mode 3.
- R9: With `wrap_en` low, writing line 63 sets `full_o`. The counter then holds at 126 and further entries are ignored.
- R10: With `wrap_en` high, the line after line 63 is written to line 0. `full_o` stays set.
- R11: When `trace_en` falls while the half bit is set, the pending entry is written to the current line as {32'b0, entry}. The counter does not change.
- R12: Reset clears `cnt_o`, `full_o` and `rd_data`. A pulse on `rd_en` loads line `rd_addr` into `rd_data` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Capture enable; its falling edge flushes a half line |
| mode | input | 2 | 0 both, 1 CPU only, 2 coprocessor only, 3 detail |
| wrap_en | input | 1 | Wrap to line 0 instead of stopping when full |
| cpu_cof | input | 1 | CPU change-of-flow strobe |
| cpu_pc | input | 24 | CPU program counter |
| cpu_attr | input | 7 | CPU info attributes |
| cop_cof | input | 1 | Coprocessor change-of-flow strobe |
| cop_pc | input | 16 | Coprocessor program counter |
| cop_attr | input | 7 | Coprocessor info attributes |
| acc_vld | input | 1 | Detail access strobe |
| acc_rd | input | 1 | Access is a read |
| acc_word | input | 1 | Access is a word, not a byte |
| det_src | input | 1 | Source being detail-traced (0 CPU, 1 coprocessor) |
| acc_cpu_addr | input | 24 | CPU address of the access |
| acc_cop_addr | input | 16 | Coprocessor address of the access |
| acc_data | input | 16 | Access data; [15:8] is the lower-address byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Line to read |
| rd_data | output | 64 | Line read back |
| cnt_o | output | 7 | {line index, half bit} |
| full_o | output | 1 | Last line has been written |

## Verification
Mode 0 is exercised three ways: a CPU-only strobe, a coprocessor-only strobe, and both strobes in the same cycle. This separates swapped valid flags from a missing snapshot. The single-source modes receive an odd number of entries, interleaved with strobes from the other source. This exposes wrong half ordering, counter bit 0 behaviour and the flush of the final entry. Detail mode is driven with one byte access and one word access using asymmetric data, so that swapped or uncleared bytes show up. Long runs of 64 and 65 entries separate the stop behaviour from the wrap behaviour.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  localparam int CPU_PC_W = 24;
  localparam int COP_PC_W = 16;
  localparam int ATTR_W   = 7;
  localparam int LINE_W   = 64;
  localparam int HALF_W   = LINE_W / 2;

  typedef enum logic [1:0] {
    TM_BOTH = 2'd0,
    TM_CPU  = 2'd1,
    TM_COP  = 2'd2,
    TM_DET  = 2'd3
  } trace_mode_e;
endpackage

// File: rtl/cof_trace_pack.sv
module cof_trace_pack
  import cof_trace_pkg::*;
(
  input  trace_mode_e          mode,
  input  logic                 cpu_cof,
  input  logic [CPU_PC_W-1:0]  cpu_pc,
  input  logic [ATTR_W-1:0]    cpu_attr,
  input  logic                 cop_cof,
  input  logic [COP_PC_W-1:0]  cop_pc,
  input  logic [ATTR_W-1:0]    cop_attr,
  input  logic                 acc_vld,
  input  logic                 acc_rd,
  input  logic                 acc_word,
  input  logic                 det_src,
  input  logic [CPU_PC_W-1:0]  acc_cpu_addr,
  input  logic [COP_PC_W-1:0]  acc_cop_addr,
  input  logic [15:0]          acc_data,
  output logic                 ev,
  output logic                 single,
  output logic [HALF_W-1:0]    ent_half,
  output logic [LINE_W-1:0]    ent_line
);
  logic [7:0] data_hi;
  logic [7:0] det_info;

  // lower-address byte goes to buffer byte 3 only for word accesses
  assign data_hi  = acc_word ? acc_data[15:8] : 8'h00;
  assign det_info = {acc_rd, acc_word, det_src, 5'b00000};

  always_comb begin
    ev       = 1'b0;
    single   = 1'b0;
    ent_half = '0;
    ent_line = '0;
    unique case (mode)
      TM_BOTH: begin
        ev       = cpu_cof | cop_cof;
        ent_line = {cop_cof, cop_attr, 8'h00, cop_pc, cpu_cof, cpu_attr, cpu_pc};
      end
      TM_CPU: begin
        ev       = cpu_cof;
        single   = 1'b1;
        ent_half = {1'b1, cpu_attr, cpu_pc};
      end
      TM_COP: begin
        ev       = cop_cof;
        single   = 1'b1;
        ent_half = {8'h00, 1'b1, cop_attr, cop_pc};
      end
      TM_DET: begin
        ev       = acc_vld;
        ent_line = {det_info, acc_cpu_addr, data_hi, acc_data[7:0], acc_cop_addr};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cof_trace_ctr.sv
module cof_trace_ctr #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          single,
  input  logic          flush_req,
  input  logic          wrap_en,
  output logic [LW-1:0] line_q,
  output logic          half_q,
  output logic          full_q,
  output logic          wr_en,
  output logic          wr_flush,
  output logic          hold_ld
);
  localparam logic [LW-1:0] LAST = LW'(DEPTH - 1);

  logic [LW-1:0] line_n;
  logic          half_n;
  logic          full_n;
  logic          blocked;
  logic          accept;
  logic          advance;

  assign blocked = full_q & ~wrap_en;
  assign accept  = ev & ~blocked;

  always_comb begin
    line_n   = line_q;
    half_n   = half_q;
    full_n   = full_q;
    wr_en    = 1'b0;
    wr_flush = 1'b0;
    hold_ld  = 1'b0;
    advance  = 1'b0;
    if (accept) begin
      if (single && !half_q) begin
        hold_ld = 1'b1;
        half_n  = 1'b1;
      end else begin
        wr_en   = 1'b1;
        half_n  = 1'b0;
        advance = 1'b1;
      end
    end else if (flush_req && half_q) begin
      wr_en    = 1'b1;
      wr_flush = 1'b1;
    end
    if (advance) begin
      if (line_q == LAST) begin
        full_n = 1'b1;
        line_n = wrap_en ? '0 : line_q;
      end else begin
        line_n = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      line_q <= line_n;
      half_q <= half_n;
      full_q <= full_n;
    end
  end
endmodule

// File: rtl/cof_trace_ram.sv
module cof_trace_ram #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trace_en,
  input  logic [1:0]          mode,
  input  logic                wrap_en,
  input  logic                cpu_cof,
  input  logic [CPU_PC_W-1:0] cpu_pc,
  input  logic [ATTR_W-1:0]   cpu_attr,
  input  logic                cop_cof,
  input  logic [COP_PC_W-1:0] cop_pc,
  input  logic [ATTR_W-1:0]   cop_attr,
  input  logic                acc_vld,
  input  logic                acc_rd,
  input  logic                acc_word,
  input  logic                det_src,
  input  logic [CPU_PC_W-1:0] acc_cpu_addr,
  input  logic [COP_PC_W-1:0] acc_cop_addr,
  input  logic [15:0]         acc_data,
  input  logic                rd_en,
  input  logic [LW-1:0]       rd_addr,
  output logic [LINE_W-1:0]   rd_data,
  output logic [LW:0]         cnt_o,
  output logic                full_o
);
  logic              rst_meta, rst_q;
  logic              trace_q;
  logic              ev, single, flush_req;
  logic [HALF_W-1:0] ent_half, hold_q;
  logic [LINE_W-1:0] ent_line, wr_data;
  logic [LW-1:0]     line_q;
  logic              half_q, full_q;
  logic              wr_en, wr_flush, hold_ld;
  logic              cpu_cof_g, cop_cof_g, acc_vld_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign cpu_cof_g = cpu_cof & trace_en;
  assign cop_cof_g = cop_cof & trace_en;
  assign acc_vld_g = acc_vld & trace_en;

  cof_trace_pack u_pack (
    .mode         (trace_mode_e'(mode)),
    .cpu_cof      (cpu_cof_g),
    .cpu_pc       (cpu_pc),
    .cpu_attr     (cpu_attr),
    .cop_cof      (cop_cof_g),
    .cop_pc       (cop_pc),
    .cop_attr     (cop_attr),
    .acc_vld      (acc_vld_g),
    .acc_rd       (acc_rd),
    .acc_word     (acc_word),
    .det_src      (det_src),
    .acc_cpu_addr (acc_cpu_addr),
    .acc_cop_addr (acc_cop_addr),
    .acc_data     (acc_data),
    .ev           (ev),
    .single       (single),
    .ent_half     (ent_half),
    .ent_line     (ent_line)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) trace_q <= 1'b0;
    else        trace_q <= trace_en;
  end
  assign flush_req = trace_q & ~trace_en;

  cof_trace_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_q),
    .ev        (ev),
    .single    (single),
    .flush_req (flush_req),
    .wrap_en   (wrap_en),
    .line_q    (line_q),
    .half_q    (half_q),
    .full_q    (full_q),
    .wr_en     (wr_en),
    .wr_flush  (wr_flush),
    .hold_ld   (hold_ld)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       hold_q <= '0;
    else if (hold_ld) hold_q <= ent_half;
  end

  always_comb begin
    if (wr_flush)    wr_data = {{HALF_W{1'b0}}, hold_q};
    else if (single) wr_data = {ent_half, hold_q};
    else             wr_data = ent_line;
  end

  cof_trace_ram #(.DEPTH(DEPTH), .WIDTH(LINE_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_q),
    .we    (wr_en),
    .waddr (line_q),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign cnt_o  = {line_q, half_q};
  assign full_o = full_q;
endmodule

// File: rtl/cof_trace_buf_chk.sv
module cof_trace_buf_chk #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        trace_en,
  input logic [1:0]  mode,
  input logic        wrap_en,
  input logic        cpu_cof,
  input logic        cop_cof,
  input logic [LW:0] cnt_o,
  input logic        full_o
);
  localparam logic [LW-1:0] LAST = LW'(DEPTH - 1);
  logic single_mode;
  assign single_mode = (mode == 2'd1) || (mode == 2'd2);

  // R5: half bit never rises outside the single-source modes
  assert_half_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_o[0] && !single_mode) |=> !cnt_o[0]);

  // R9: full flag is sticky
  assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> full_o);

  // R9: no movement once full without wrap
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !wrap_en) |=> $stable(cnt_o));

  // R8: counter frozen while capture is off
  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> $stable(cnt_o));

  // R3: second CPU entry completes the line
  assert_pair_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && trace_en && cpu_cof && cnt_o[0] && !full_o) |=> !cnt_o[0]);

  // R1: one strobe in both-source mode advances one line
  assert_both_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && trace_en && (cpu_cof || cop_cof) && !full_o && cnt_o[LW:1] != LAST)
    |=> cnt_o[LW:1] == $past(cnt_o[LW:1]) + 1'b1);
endmodule

bind cof_trace_buf cof_trace_buf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_q),
  .trace_en (trace_en),
  .mode     (mode),
  .wrap_en  (wrap_en),
  .cpu_cof  (cpu_cof),
  .cop_cof  (cop_cof),
  .cnt_o    (cnt_o),
  .full_o   (full_o)
);

// File: tb/cof_trace_buf_tb_top.sv
`timescale 1ns/1ps
module cof_trace_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trace_en, wrap_en, cpu_cof, cop_cof, acc_vld, acc_rd, acc_word, det_src, rd_en;
  logic [1:0]  mode;
  logic [23:0] cpu_pc, acc_cpu_addr;
  logic [15:0] cop_pc, acc_cop_addr, acc_data;
  logic [6:0]  cpu_attr, cop_attr;
  logic [5:0]  rd_addr;
  logic [63:0] rd_data;
  logic [6:0]  cnt_o;
  logic        full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cof_trace_buf dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(bit wrap);
    @(negedge clk);
    rst_n = 1'b0; trace_en = 0; wrap_en = wrap; mode = 0;
    cpu_cof = 0; cop_cof = 0; acc_vld = 0; acc_rd = 0; acc_word = 0; det_src = 0;
    rd_en = 0; rd_addr = 0; cpu_pc = 0; cop_pc = 0; cpu_attr = 0; cop_attr = 0;
    acc_cpu_addr = 0; acc_cop_addr = 0; acc_data = 0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic cof(bit c, bit x);
    cpu_cof = c; cop_cof = x;
    step();
    cpu_cof = 0; cop_cof = 0;
  endtask

  task automatic rd_line(int a, output logic [63:0] d);
    rd_addr = 6'(a); rd_en = 1;
    step();
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic t_reset();
    do_reset(0);
    chk("R12 cnt", 64'(cnt_o), 0);
    chk("R12 full", 64'(full_o), 0);
    chk("R12 rdata", rd_data, 0);
  endtask

  task automatic t_both();
    logic [63:0] d;
    do_reset(0);
    mode = 0; trace_en = 1; cpu_attr = 7'h15; cop_attr = 7'h2A;
    cpu_pc = 24'h123456; cop_pc = 16'hBEEF;
    cof(1, 0);
    cpu_pc = 24'hABCDEF; cop_pc = 16'h1357;
    cof(0, 1);
    cpu_pc = 24'h0F0F0F; cop_pc = 16'h2468;
    cof(1, 1);
    chk("R5 both cnt", 64'(cnt_o), 6);
    trace_en = 0; cpu_pc = 24'h777777;
    cof(1, 1);
    chk("R8 idle cnt", 64'(cnt_o), 6);
    rd_line(0, d);
    chk("R1 cpu strobe line", d, {8'h2A, 8'h00, 16'hBEEF, 8'h95, 24'h123456});
    rd_line(1, d);
    chk("R1 cop strobe line", d, {8'hAA, 8'h00, 16'h1357, 8'h15, 24'hABCDEF});
    rd_line(2, d);
    chk("R2 joint line", d, {8'hAA, 8'h00, 16'h2468, 8'h95, 24'h0F0F0F});
    rd_line(3, d);
    chk("R12 unwritten stays reset-free check via cnt", 64'(cnt_o), 6);
  endtask

  task automatic t_cpu_only();
    logic [63:0] d;
    do_reset(0);
    mode = 1; trace_en = 1; cpu_attr = 7'h01;
    cpu_pc = 24'h111111; cof(1, 0);
    chk("R5 half set", 64'(cnt_o), 1);
    cop_pc = 16'hDEAD; cof(0, 1);
    chk("R8 other source ignored", 64'(cnt_o), 1);
    acc_vld = 1; step(); acc_vld = 0;
    chk("R8 access ignored in flow", 64'(cnt_o), 1);
    cpu_attr = 7'h02; cpu_pc = 24'h222222; cof(1, 0);
    chk("R5 line done", 64'(cnt_o), 2);
    cpu_attr = 7'h03; cpu_pc = 24'h333333; cof(1, 0);
    trace_en = 0; step();
    chk("R11 cnt kept", 64'(cnt_o), 3);
    rd_line(0, d);
    chk("R3 pair order", d, {8'h82, 24'h222222, 8'h81, 24'h111111});
    rd_line(1, d);
    chk("R11 flushed half", d, {32'h0, 8'h83, 24'h333333});
  endtask

  task automatic t_cop_only();
    logic [63:0] d;
    do_reset(0);
    mode = 2; trace_en = 1; cop_attr = 7'h10;
    cop_pc = 16'hA1A2; cof(0, 1);
    cpu_pc = 24'h999999; cof(1, 0);
    cop_attr = 7'h11; cop_pc = 16'hB1B2; cof(0, 1);
    chk("R5 cop cnt", 64'(cnt_o), 2);
    rd_line(0, d);
    chk("R4 cop pair", d, {8'h00, 8'h91, 16'hB1B2, 8'h00, 8'h90, 16'hA1A2});
  endtask

  task automatic t_detail();
    logic [63:0] d;
    do_reset(0);
    mode = 3; trace_en = 1;
    acc_cpu_addr = 24'h400102; acc_cop_addr = 16'h8004; acc_data = 16'h5A3C;
    acc_rd = 1; acc_word = 0; det_src = 0;
    acc_vld = 1; step(); acc_vld = 0;
    acc_cpu_addr = 24'h400200; acc_cop_addr = 16'h9006; acc_data = 16'hC3E1;
    acc_rd = 0; acc_word = 1; det_src = 1;
    acc_vld = 1; step(); acc_vld = 0;
    cof(1, 1);
    chk("R8 cof ignored in detail", 64'(cnt_o), 4);
    rd_line(0, d);
    chk("R7 byte access", d, {8'h80, 24'h400102, 8'h00, 8'h3C, 16'h8004});
    rd_line(1, d);
    chk("R6 R7 word access", d, {8'h60, 24'h400200, 8'hC3, 8'hE1, 16'h9006});
  endtask

  task automatic t_saturate();
    logic [63:0] d;
    do_reset(0);
    mode = 0; trace_en = 1; cpu_attr = 0; cop_attr = 0; cop_pc = 0;
    for (int i = 0; i < 64; i++) begin
      cpu_pc = 24'(i); cof(1, 0);
    end
    chk("R9 full", 64'(full_o), 1);
    chk("R9 cnt held", 64'(cnt_o), 126);
    cpu_pc = 24'hABCDEF; cof(1, 0);
    chk("R9 cnt after extra", 64'(cnt_o), 126);
    rd_line(63, d);
    chk("R9 last line kept", d, {32'h0, 8'h80, 24'd63});
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    do_reset(1);
    mode = 0; trace_en = 1; cpu_attr = 0; cop_attr = 0; cop_pc = 0;
    for (int i = 0; i < 65; i++) begin
      cpu_pc = 24'(i); cof(1, 0);
    end
    chk("R10 full", 64'(full_o), 1);
    chk("R10 cnt wrapped", 64'(cnt_o), 2);
    rd_line(0, d);
    chk("R10 line0 overwritten", d, {32'h0, 8'h80, 24'd64});
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_both();
    t_cpu_only();
    t_cop_only();
    t_detail();
    t_saturate();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule